// File: doc/BRIEF.md
# Self-Checking Dual-Rail Equality Comparator Tree

This block decides whether two N-bit operands are equal. Every operand bit arrives as a pair of wires that normally hold opposite values. The result leaves the block as a pair coded the same way. At each bit position a two-input cell produces a dual-rail "this bit differs" signal. A tree of dual-rail merge cells then folds these signals into a single pair at the root.

Each rail of the tree is computed only from rails of the same polarity. As a result, a single stuck line inside the tree can only push the output pair to 00 or 11. It can never turn the output into the opposite valid result. An error flag is raised when the output pair is non-coded and also when any operand pair arrives non-coded.

A fault-injection port forces any one internal rail to a chosen constant. This lets the detection property be shown on every net. The result and the error flag are registered, so they appear one clock after the inputs.

Top module: `tsc_eq_tree`

## Requirements
- R1: A dual-rail pair (true rail, false rail) encodes logic 1 as 10 and logic 0 as 01; 00 and 11 are non-code. Operand bit i travels on a_t_i[i] and a_f_i[i] (and likewise on b_t_i[i] and b_f_i[i]).
- R2: With coded operands and no active fault, res_o one clock after the inputs is 2'b10 when the operands differ in any bit and 2'b01 when they are equal.
- R3: If any operand pair is 00 or 11, err_o is 1 one clock later.
- R4: err_o is 1 whenever res_o is 00 or 11. With coded operands and no active fault it is 0.
- R5: Nets are numbered net = 2*node + rail, where rail 0 is the true rail and rail 1 the false rail. Node 1 is the root, and node k merges nodes 2k and 2k+1. Operand bit i enters at leaf node LEAVES+i, where LEAVES is the smallest power of two not below N. While flt_en_i is 1, the net selected by flt_net_i is forced to flt_val_i.
- R6: Fault-secure: with coded operands and any single injected stuck value, res_o is either the correct code word with err_o 0, or non-code with err_o 1. It is never the wrong code word.
- R7: Self-testing: for every injectable net and both stuck values, at least one coded operand pair gives a non-code res_o.
- R8: For N that is not a power of two, leaf positions N..LEAVES-1 hold a constant "equal" code. Merge nodes over those positions pass their real child through, so every operand bit, including bit N-1, reaches the root through the same number of levels.
- R9: While rst_ni is low, res_o is 2'b01 and err_o is 0.
- R10: With flt_en_i low, or with flt_net_i naming a node that covers only padding positions, the result equals the fault-free result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_t_i | input | N | Operand A, true rails |
| a_f_i | input | N | Operand A, false rails |
| b_t_i | input | N | Operand B, true rails |
| b_f_i | input | N | Operand B, false rails |
| flt_en_i | input | 1 | Enable stuck-value injection |
| flt_net_i | input | NET_W | Net selected for injection (2*node + rail) |
| flt_val_i | input | 1 | Stuck value forced on the selected net |
| res_o | output | 2 | Dual-rail result: 10 differ, 01 equal |
| err_o | output | 1 | Non-code operand or non-code result |

## Verification
The hard case is an internal line that is stuck while the operands are clean. From the operand ports alone, such a fault either stays silent or shows up as a bad code. Reaching it needs the injection port together with the right difference pattern. For example, a stuck-at-1 on a true rail only shows when every bit is equal. A stuck-at-0 on a true rail only shows when the differing bits all lie under that node. The stimulus therefore sweeps every real net and both stuck values over all 2^N difference patterns, each on a shifted base value. Every result is checked as either correct-and-clean or flagged non-code, and each sweep must produce at least one flagged result.

// File: rtl/tsc_cmp_pkg.sv
package tsc_cmp_pkg;

  localparam logic [1:0] DR_DIFF  = 2'b10;
  localparam logic [1:0] DR_EQUAL = 2'b01;

  // leftmost leaf below a heap node
  function automatic int unsigned first_leaf(int unsigned node, int unsigned leaves);
    int unsigned f;
    f = node;
    for (int i = 0; i < 32; i++) begin
      if (f < leaves) f = f << 1;
    end
    return f;
  endfunction

  // node covers at least one real operand bit
  function automatic bit node_real(int unsigned node, int unsigned leaves, int unsigned n);
    return (first_leaf(node, leaves) - leaves) < n;
  endfunction

endpackage

// File: rtl/tsc_xor_cell.sv
module tsc_xor_cell (
  input  logic a_t_i,
  input  logic a_f_i,
  input  logic b_t_i,
  input  logic b_f_i,
  output logic d_t_o,
  output logic d_f_o
);

  assign d_t_o = (a_t_i & b_f_i) | (a_f_i & b_t_i);
  assign d_f_o = (a_t_i & b_t_i) | (a_f_i & b_f_i);

  // R1
  always_comb begin
    if ((a_t_i ^ a_f_i) && (b_t_i ^ b_f_i)) begin
      xor_code_chk: assert (d_t_o ^ d_f_o);
    end
  end

endmodule

// File: rtl/tsc_or_cell.sv
module tsc_or_cell (
  input  logic x_t_i,
  input  logic x_f_i,
  input  logic y_t_i,
  input  logic y_f_i,
  output logic o_t_o,
  output logic o_f_o
);

  // true rail sees only true rails, false rail only false rails
  assign o_t_o = x_t_i | y_t_i;
  assign o_f_o = x_f_i & y_f_i;

  // R6
  always_comb begin
    if ((x_t_i ^ x_f_i) && (y_t_i ^ y_f_i)) begin
      or_code_chk: assert (o_t_o ^ o_f_o);
    end
  end

endmodule

// File: rtl/tsc_fault_tap.sv
module tsc_fault_tap #(
  parameter int unsigned NET_W = 5,
  parameter int unsigned ID    = 0
) (
  input  logic             net_i,
  input  logic             en_i,
  input  logic [NET_W-1:0] sel_i,
  input  logic             val_i,
  output logic             net_o
);

  localparam logic [NET_W-1:0] ID_V = NET_W'(ID);

  assign net_o = (en_i && (sel_i == ID_V)) ? val_i : net_i;

endmodule

// File: rtl/tsc_eq_tree.sv
module tsc_eq_tree #(
  parameter int unsigned N     = 6,
  parameter int unsigned NET_W = $clog2(N) + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     a_t_i,
  input  logic [N-1:0]     a_f_i,
  input  logic [N-1:0]     b_t_i,
  input  logic [N-1:0]     b_f_i,
  input  logic             flt_en_i,
  input  logic [NET_W-1:0] flt_net_i,
  input  logic             flt_val_i,
  output logic [1:0]       res_o,
  output logic             err_o
);

  import tsc_cmp_pkg::*;

  localparam int unsigned DEPTH  = $clog2(N);
  localparam int unsigned LEAVES = 1 << DEPTH;
  localparam int unsigned NODES  = 2 * LEAVES;

  logic [NODES-1:1] raw_t, raw_f;
  logic [NODES-1:1] nt, nf;
  logic             in_ok;
  logic [1:0]       res_q;
  logic             err_q;

  assign in_ok = (&(a_t_i ^ a_f_i)) & (&(b_t_i ^ b_f_i));

  for (genvar k = 1; k < NODES; k++) begin : g_node
    if (k >= LEAVES) begin : g_leaf
      if (k - LEAVES < N) begin : g_bit
        tsc_xor_cell u_xor (
          .a_t_i (a_t_i[k-LEAVES]),
          .a_f_i (a_f_i[k-LEAVES]),
          .b_t_i (b_t_i[k-LEAVES]),
          .b_f_i (b_f_i[k-LEAVES]),
          .d_t_o (raw_t[k]),
          .d_f_o (raw_f[k])
        );
      end else begin : g_pad
        assign raw_t[k] = 1'b0;
        assign raw_f[k] = 1'b1;
      end
    end else begin : g_merge
      tsc_or_cell u_or (
        .x_t_i (nt[2*k]),
        .x_f_i (nf[2*k]),
        .y_t_i (nt[2*k+1]),
        .y_f_i (nf[2*k+1]),
        .o_t_o (raw_t[k]),
        .o_f_o (raw_f[k])
      );
    end

    if (node_real(k, LEAVES, N)) begin : g_tap
      tsc_fault_tap #(.NET_W(NET_W), .ID(2*k)) u_tap_t (
        .net_i (raw_t[k]),
        .en_i  (flt_en_i),
        .sel_i (flt_net_i),
        .val_i (flt_val_i),
        .net_o (nt[k])
      );
      tsc_fault_tap #(.NET_W(NET_W), .ID(2*k+1)) u_tap_f (
        .net_i (raw_f[k]),
        .en_i  (flt_en_i),
        .sel_i (flt_net_i),
        .val_i (flt_val_i),
        .net_o (nf[k])
      );
    end else begin : g_notap
      assign nt[k] = raw_t[k];
      assign nf[k] = raw_f[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= DR_EQUAL;
      err_q <= 1'b0;
    end else begin
      res_q <= {nt[1], nf[1]};
      err_q <= ~in_ok | ~(nt[1] ^ nf[1]);
    end
  end

  assign res_o = res_q;
  assign err_o = err_q;

  // R2
  cmp_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flt_en_i && in_ok) |=> (res_o == (($past(a_t_i) != $past(b_t_i)) ? DR_DIFF : DR_EQUAL)));

  // R3
  bad_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ok |=> err_o);

  // R4
  err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> (res_o[1] != res_o[0]));

  // R6
  fault_secure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ok |=> (err_o || (res_o == (($past(a_t_i) != $past(b_t_i)) ? DR_DIFF : DR_EQUAL))));

endmodule

// File: tb/tb_tsc_eq_tree.sv
`timescale 1ns/1ps
module tb_tsc_eq_tree;

  localparam int N      = 6;
  localparam int DEPTH  = $clog2(N);
  localparam int LEAVES = 1 << DEPTH;
  localparam int NET_W  = DEPTH + 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N-1:0]     a_t, a_f, b_t, b_f;
  logic             flt_en;
  logic [NET_W-1:0] flt_net;
  logic             flt_val;
  logic [1:0]       res;
  logic             err;

  always #2 clk = ~clk;

  tsc_eq_tree #(.N(N), .NET_W(NET_W)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .a_t_i     (a_t),
    .a_f_i     (a_f),
    .b_t_i     (b_t),
    .b_f_i     (b_f),
    .flt_en_i  (flt_en),
    .flt_net_i (flt_net),
    .flt_val_i (flt_val),
    .res_o     (res),
    .err_o     (err)
  );

  typedef struct {
    int       issue;
    int       mode;   // 0 exact, 1 fault-secure, 2 error only
    logic [1:0] exp_res;
    logic     exp_err;
  } item_t;

  item_t q[$];
  string tag_q[$];
  int    cyc = 0;
  int    n_run = 0;
  int    n_fail = 0;
  bit    seen_nc;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: result of an item is visible one cycle after issue
  always @(negedge clk) begin
    item_t it;
    string tg;
    bit    ok;
    while (q.size() > 0 && q[0].issue < cyc) begin
      it = q.pop_front();
      tg = tag_q.pop_front();
      n_run++;
      case (it.mode)
        0: ok = (res == it.exp_res) && (err == it.exp_err);
        1: begin
          ok = ((res == it.exp_res) && !err) || ((res[1] == res[0]) && err);
          if (res[1] == res[0]) seen_nc = 1'b1;
        end
        default: ok = (err == it.exp_err);
      endcase
      if (!ok) begin
        n_fail++;
        $display("FAIL %s: res=%b err=%b expected res=%b err=%b (mode %0d)",
                 tg, res, err, it.exp_res, it.exp_err, it.mode);
      end
    end
  end

  task automatic put(input logic [N-1:0] at, input logic [N-1:0] af,
                     input logic [N-1:0] bt, input logic [N-1:0] bf,
                     input logic en, input logic [NET_W-1:0] net, input logic v,
                     input int mode, input logic [1:0] er, input logic ee,
                     input string tg);
    item_t it;
    @(negedge clk);
    a_t = at; a_f = af; b_t = bt; b_f = bf;
    flt_en = en; flt_net = net; flt_val = v;
    it.issue = cyc; it.mode = mode; it.exp_res = er; it.exp_err = ee;
    q.push_back(it);
    tag_q.push_back(tg);
  endtask

  task automatic put_op(input logic [N-1:0] a, input logic [N-1:0] b,
                        input logic en, input logic [NET_W-1:0] net, input logic v,
                        input int mode, input logic [1:0] er, input logic ee,
                        input string tg);
    put(a, ~a, b, ~b, en, net, v, mode, er, ee, tg);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic direct_chk(input bit ok, input string tg, input logic [1:0] r, input logic e,
                            input logic [1:0] er, input logic ee);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: res=%b err=%b expected res=%b err=%b", tg, r, e, er, ee);
    end
  endtask

  function automatic bit is_real(int node);
    int f;
    f = node;
    while (f < LEAVES) f = f * 2;
    return (f - LEAVES) < N;
  endfunction

  initial begin
    #(200000 * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] base, a, b;
    a_t = '0; a_f = '1; b_t = '0; b_f = '1;
    flt_en = 1'b0; flt_net = '0; flt_val = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state, including while inputs move
    direct_chk(res == 2'b01 && err == 1'b0, "R9", res, err, 2'b01, 1'b0);
    a_t = 1; a_f = ~a_t;
    @(negedge clk);
    direct_chk(res == 2'b01 && err == 1'b0, "R9", res, err, 2'b01, 1'b0);
    rst_ni = 1'b1;

    // R2 / R1: every difference pattern on a moving base
    for (int d = 0; d < (1 << N); d++) begin
      base = N'(d * 37 + 11);
      a = base ^ N'(d);
      b = base;
      put_op(a, b, 1'b0, '0, 1'b0, 0, (d != 0) ? 2'b10 : 2'b01, 1'b0, "R2");
    end
    // R4: clean inputs, no fault, equal operands keep err low
    put_op('1, '1, 1'b0, '0, 1'b0, 0, 2'b01, 1'b0, "R4");

    // R8: single-bit difference at every position, including the top one
    for (int i = 0; i < N; i++) begin
      put_op(N'(1) << i, '0, 1'b0, '0, 1'b0, 0, 2'b10, 1'b0, "R8");
    end

    // R3: non-code pair on either operand, 11 and 00
    for (int i = 0; i < N; i++) begin
      a = N'(1) << i;
      put(a, a, '0, '1, 1'b0, '0, 1'b0, 2, 2'b00, 1'b1, "R3");
      put('0, ~a, '0, '1, 1'b0, '0, 1'b0, 2, 2'b00, 1'b1, "R3");
      put('0, '1, a, ~a | a, 1'b0, '0, 1'b0, 2, 2'b00, 1'b1, "R3");
    end

    // R5: numbering; leaf of bit 0 true rail stuck 1, equal operands -> 11
    put_op('0, '0, 1'b1, NET_W'(2 * LEAVES), 1'b1, 0, 2'b11, 1'b1, "R5");
    // R5: root false rail (net 3) stuck 0, equal operands -> 00
    put_op('0, '0, 1'b1, NET_W'(3), 1'b0, 0, 2'b00, 1'b1, "R5");
    // R5: root true rail (net 2) stuck 0, operands differ -> 00
    put_op(N'(1), '0, 1'b1, NET_W'(2), 1'b0, 0, 2'b00, 1'b1, "R5");

    // R10: injection disabled has no effect
    put_op('0, '0, 1'b0, NET_W'(2 * LEAVES), 1'b1, 0, 2'b01, 1'b0, "R10");
    put_op(N'(2), '0, 1'b0, NET_W'(2), 1'b0, 0, 2'b10, 1'b0, "R10");
    // R10: net on a padding-only node has no effect
    if (N < LEAVES) begin
      put_op('0, '0, 1'b1, NET_W'(2 * (2 * LEAVES - 1)), 1'b1, 0, 2'b01, 1'b0, "R10");
      put_op(N'(1) << (N - 1), '0, 1'b1, NET_W'(2 * (2 * LEAVES - 1) + 1), 1'b0, 0,
             2'b10, 1'b0, "R10");
    end
    drain();

    // R6 / R7: every real net, both stuck values, all difference patterns
    for (int k = 1; k < 2 * LEAVES; k++) begin
      if (is_real(k)) begin
        for (int r = 0; r < 2; r++) begin
          for (int v = 0; v < 2; v++) begin
            seen_nc = 1'b0;
            for (int d = 0; d < (1 << N); d++) begin
              base = N'(d * 13 + k);
              put_op(base ^ N'(d), base, 1'b1, NET_W'(2 * k + r), v[0], 1,
                     (d != 0) ? 2'b10 : 2'b01, 1'b0, "R6");
            end
            drain();
            // R7 every fault shows as non-code for some input
            n_run++;
            if (!seen_nc) begin
              n_fail++;
              $display("FAIL R7: net %0d stuck %0d never gave non-code, expected at least one",
                       2 * k + r, v);
            end
          end
        end
      end
    end

    drain();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule